// File: doc/BRIEF.md
# Internal Error Router for Port Functions

This block sits in one port of a packet switch and turns internal error events into the internal-error fields of each function's error-reporting capability. A port can hold up to three functions: a bridge function, a non-transparent (NT) function and a DMA function. The port mode decides which of them are present. Error sources come from detectors elsewhere in the port, such as core timers, memory ECC checkers and datapath parity checkers. Each detection arrives as a one-cycle pulse on its own bit of `err_pulse`.

Every source has a sticky log bit. An error is steered to functions by its class. DMA-path errors reach only the DMA function. Errors promoted from the port's own error reporting reach only the bridge function. Every other error reaches all functions that are present. Each function can block any source with its own mask. One port-level enable gates propagation into all functions, and while it is clear it also freezes every function's internal-error fields against writes. Uncorrectable errors do not capture a packet header. Instead the function's header log is filled with all ones, as long as its first-error pointer is free.

Top module: `ierr_router`

## Requirements
- R1: A pulse on source i sets source status bit i (source i sits at register word 1 + i/16, bit i%16). Writing a one to that bit clears it, but a pulse in the same cycle as the clearing write keeps the bit set.
- R2: While the port enable (register 0, bit 0, reset value 1) is 0, pulses are still logged in the source status, but no function's correctable or uncorrectable status is set.
- R3: Each function's internal-error field register sits at function base + 2. Its fields are: bit 0 uncorrectable status (write-one-to-clear), bit 1 uncorrectable mask, bit 2 severity, bit 3 correctable status (write-one-to-clear), bit 4 correctable mask, bit 5 header-overflow mask. Writes to this register take effect only while the port enable is 1.
- R4: Sources 4 to 11 (DMA path) set status only in the DMA function.
- R5: Sources 12 and 13 (promoted port errors) set status only in the bridge function.
- R6: All other sources set status in every present function. The present functions are set by port_mode: 0 gives bridge only, 1 gives bridge and DMA, 2 gives NT and DMA, 3 gives all three. An absent function never sets status and reads as zero. Function bases are 8 (bridge), 16 (NT) and 24 (DMA), with function index 0, 1 and 2 on the per-function outputs.
- R7: A 1 in a function's mask blocks that source from that function. Source i uses mask word base + i/16, bit i%16. Unmasked functions are unaffected.
- R8: Sources 1, 7, 9, 13 and 14 are correctable and set the correctable status. All other sources set the uncorrectable status.
- R9: An uncorrectable error fills the function's header-log words (base + 4 to base + 7) with all ones and marks the header held. This happens only if the error is not masked in the function's fields and no header is already held. Clearing the uncorrectable status releases the held header and zeroes the log.
- R10: After reset the port enable is 1, and all status, mask, field and header registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_mode | input | 2 | Selects which functions are present |
| err_pulse | input | NUM_SRC | One-cycle detection pulse per error source |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| fn_corr_sts | output | 3 | Correctable internal-error status per function |
| fn_uncorr_sts | output | 3 | Uncorrectable internal-error status per function |
| fn_hdr_held | output | 3 | Header log held per function |

## Verification
The hardest case to reach from the ports is a source pulse that lands in the same cycle as a software clear of that same bit. The bench drives the clearing write and the pulse on the same falling edge, so both are seen at one rising edge. It also checks the held-header release. To do that it first fills a header, then clears the uncorrectable status, and then raises a second uncorrectable error while the function's uncorrectable mask is set. At that point the header must stay empty even though the status sets.

// File: rtl/ierr_pkg.sv
package ierr_pkg;

    localparam int NFUNC     = 3;
    localparam int FN_BRIDGE = 0;
    localparam int FN_NT     = 1;
    localparam int FN_DMA    = 2;

    // Per-function internal-error fields, bit 0 at the bottom
    typedef struct packed {
        logic hlo_mask;
        logic cie_mask;
        logic cie_sts;
        logic uie_sev;
        logic uie_mask;
        logic uie_sts;
    } ie_fields_t;

    localparam int FIELD_W = $bits(ie_fields_t);

    // Which functions exist for each port mode (bit = function index)
    function automatic logic [NFUNC-1:0] present_of(input logic [1:0] mode);
        logic [NFUNC-1:0] p;
        case (mode)
            2'd0:    p = 3'b001;
            2'd1:    p = 3'b101;
            2'd2:    p = 3'b110;
            default: p = 3'b111;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/ierr_src_log.sv
module ierr_src_log #(
    parameter int NUM_SRC = 20,
    parameter int DATA_W  = 16,
    parameter int WORDS   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] err_pulse,
    input  logic [WORDS-1:0]   clr_word,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_SRC-1:0] sts
);

    typedef struct packed {
        logic [NUM_SRC-1:0] sts;
    } log_state_t;

    log_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (clr_word[i / DATA_W] && wdata[i % DATA_W]) begin
                state_d.sts[i] = 1'b0;
            end
            // a detection wins over a same-cycle clear
            if (err_pulse[i]) begin
                state_d.sts[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sts = state_q.sts;

endmodule

// File: rtl/ierr_route.sv
module ierr_route
    import ierr_pkg::*;
#(
    parameter int               NUM_SRC     = 20,
    parameter logic [NUM_SRC-1:0] DMA_ONLY    = '0,
    parameter logic [NUM_SRC-1:0] BRIDGE_ONLY = '0,
    parameter logic [NUM_SRC-1:0] CORR_SRC    = '0
) (
    input  logic [NUM_SRC-1:0]            err_pulse,
    input  logic                          port_en,
    input  logic [NFUNC-1:0]              present,
    input  logic [NFUNC-1:0][NUM_SRC-1:0] mask,
    output logic [NFUNC-1:0]              hit_corr,
    output logic [NFUNC-1:0]              hit_unc
);

    localparam logic [NUM_SRC-1:0] SHARED = ~(DMA_ONLY | BRIDGE_ONLY);

    for (genvar f = 0; f < NFUNC; f++) begin : g_fn
        logic [NUM_SRC-1:0] reach;
        logic [NUM_SRC-1:0] eff;

        if (f == FN_DMA) begin : g_dma
            assign reach = SHARED | DMA_ONLY;
        end else if (f == FN_BRIDGE) begin : g_brg
            assign reach = SHARED | BRIDGE_ONLY;
        end else begin : g_other
            assign reach = SHARED;
        end

        assign eff         = err_pulse & reach & ~mask[f] & {NUM_SRC{port_en & present[f]}};
        assign hit_corr[f] = |(eff & CORR_SRC);
        assign hit_unc[f]  = |(eff & ~CORR_SRC);
    end

endmodule

// File: rtl/ierr_func_aer.sv
module ierr_func_aer
    import ierr_pkg::*;
#(
    parameter int NUM_SRC    = 20,
    parameter int DATA_W     = 16,
    parameter int MASK_WORDS = 2,
    parameter int HDR_WORDS  = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 present,
    input  logic                                 port_en,
    input  logic                                 hit_corr,
    input  logic                                 hit_unc,
    input  logic [MASK_WORDS-1:0]                wr_mask,
    input  logic                                 wr_fields,
    input  logic [DATA_W-1:0]                    wdata,
    output logic [NUM_SRC-1:0]                   mask,
    output ie_fields_t                           fields,
    output logic                                 hdr_held,
    output logic [HDR_WORDS-1:0][DATA_W-1:0]     hdr
);

    typedef struct packed {
        logic [NUM_SRC-1:0]               mask;
        ie_fields_t                       fld;
        logic                             held;
        logic [HDR_WORDS-1:0][DATA_W-1:0] hdr;
    } fn_state_t;

    fn_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;

        // source mask words stay writable at all times
        for (int i = 0; i < NUM_SRC; i++) begin
            if (wr_mask[i / DATA_W]) begin
                state_d.mask[i] = wdata[i % DATA_W];
            end
        end

        // internal-error fields are frozen while the port enable is clear
        if (wr_fields && port_en) begin
            if (wdata[0]) state_d.fld.uie_sts = 1'b0;
            if (wdata[3]) state_d.fld.cie_sts = 1'b0;
            state_d.fld.uie_mask = wdata[1];
            state_d.fld.uie_sev  = wdata[2];
            state_d.fld.cie_mask = wdata[4];
            state_d.fld.hlo_mask = wdata[5];
        end

        if (hit_corr) begin
            state_d.fld.cie_sts = 1'b1;
        end

        if (hit_unc) begin
            state_d.fld.uie_sts = 1'b1;
            if (!state_q.fld.uie_mask && !state_q.held) begin
                state_d.held = 1'b1;
                state_d.hdr  = '1;
            end
        end

        // releasing the status frees the first-error pointer and its log
        if (state_q.held && !state_d.fld.uie_sts) begin
            state_d.held = 1'b0;
            state_d.hdr  = '0;
        end

        if (!present) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mask     = state_q.mask;
    assign fields   = state_q.fld;
    assign hdr_held = state_q.held;
    assign hdr      = state_q.hdr;

endmodule

// File: rtl/ierr_router.sv
module ierr_router
    import ierr_pkg::*;
#(
    parameter int                 NUM_SRC     = 20,
    parameter int                 DATA_W      = 16,
    parameter int                 ADDR_W      = 5,
    parameter int                 HDR_WORDS   = 4,
    parameter logic [NUM_SRC-1:0] DMA_ONLY    = 20'h00FF0,
    parameter logic [NUM_SRC-1:0] BRIDGE_ONLY = 20'h03000,
    parameter logic [NUM_SRC-1:0] CORR_SRC    = 20'h06282
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         port_mode,
    input  logic [NUM_SRC-1:0] err_pulse,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [NFUNC-1:0]   fn_corr_sts,
    output logic [NFUNC-1:0]   fn_uncorr_sts,
    output logic [NFUNC-1:0]   fn_hdr_held
);

    localparam int SRC_WORDS = (NUM_SRC + DATA_W - 1) / DATA_W;
    localparam int A_CTRL    = 0;
    localparam int A_SRC     = 1;
    localparam int FN_BASE   = 8;
    localparam int FN_STRIDE = 8;
    localparam int OFS_FLD   = 2;
    localparam int OFS_HDR   = 4;

    typedef struct packed {
        logic en;
    } top_state_t;

    top_state_t state_d, state_q;

    logic [NFUNC-1:0]                            present;
    logic [SRC_WORDS-1:0]                        src_clr;
    logic [NUM_SRC-1:0]                          src_sts;
    logic [NFUNC-1:0][NUM_SRC-1:0]               fn_mask;
    ie_fields_t                                  fn_fld   [NFUNC];
    logic [NFUNC-1:0][HDR_WORDS-1:0][DATA_W-1:0] fn_hdr;
    logic [NFUNC-1:0]                            hit_corr;
    logic [NFUNC-1:0]                            hit_unc;
    logic                                        port_en_q;

    assign present   = present_of(port_mode);
    assign port_en_q = state_q.en;

    // port enable register
    always_comb begin
        state_d = state_q;
        if (reg_wr && reg_addr == ADDR_W'(A_CTRL)) begin
            state_d.en = reg_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{en: 1'b1};
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar w = 0; w < SRC_WORDS; w++) begin : g_src_dec
        assign src_clr[w] = reg_wr && (reg_addr == ADDR_W'(A_SRC + w));
    end

    ierr_src_log #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W),
        .WORDS   (SRC_WORDS)
    ) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_pulse (err_pulse),
        .clr_word  (src_clr),
        .wdata     (reg_wdata),
        .sts       (src_sts)
    );

    ierr_route #(
        .NUM_SRC     (NUM_SRC),
        .DMA_ONLY    (DMA_ONLY),
        .BRIDGE_ONLY (BRIDGE_ONLY),
        .CORR_SRC    (CORR_SRC)
    ) u_route (
        .err_pulse (err_pulse),
        .port_en   (state_q.en),
        .present   (present),
        .mask      (fn_mask),
        .hit_corr  (hit_corr),
        .hit_unc   (hit_unc)
    );

    for (genvar f = 0; f < NFUNC; f++) begin : g_fn
        logic [SRC_WORDS-1:0] wr_mask;
        logic                 wr_fld;

        for (genvar w = 0; w < SRC_WORDS; w++) begin : g_mdec
            assign wr_mask[w] = reg_wr && (reg_addr == ADDR_W'(FN_BASE + f * FN_STRIDE + w));
        end
        assign wr_fld = reg_wr && (reg_addr == ADDR_W'(FN_BASE + f * FN_STRIDE + OFS_FLD));

        ierr_func_aer #(
            .NUM_SRC    (NUM_SRC),
            .DATA_W     (DATA_W),
            .MASK_WORDS (SRC_WORDS),
            .HDR_WORDS  (HDR_WORDS)
        ) u_fn (
            .clk       (clk),
            .rst_n     (rst_n),
            .present   (present[f]),
            .port_en   (state_q.en),
            .hit_corr  (hit_corr[f]),
            .hit_unc   (hit_unc[f]),
            .wr_mask   (wr_mask),
            .wr_fields (wr_fld),
            .wdata     (reg_wdata),
            .mask      (fn_mask[f]),
            .fields    (fn_fld[f]),
            .hdr_held  (fn_hdr_held[f]),
            .hdr       (fn_hdr[f])
        );

        assign fn_corr_sts[f]   = fn_fld[f].cie_sts;
        assign fn_uncorr_sts[f] = fn_fld[f].uie_sts;
    end

    // register read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_CTRL)) begin
            reg_rdata[0] = state_q.en;
        end
        for (int w = 0; w < SRC_WORDS; w++) begin
            if (reg_addr == ADDR_W'(A_SRC + w)) begin
                for (int b = 0; b < DATA_W; b++) begin
                    if (w * DATA_W + b < NUM_SRC) reg_rdata[b] = src_sts[w * DATA_W + b];
                end
            end
        end
        for (int f = 0; f < NFUNC; f++) begin
            for (int w = 0; w < SRC_WORDS; w++) begin
                if (reg_addr == ADDR_W'(FN_BASE + f * FN_STRIDE + w)) begin
                    for (int b = 0; b < DATA_W; b++) begin
                        if (w * DATA_W + b < NUM_SRC) reg_rdata[b] = fn_mask[f][w * DATA_W + b];
                    end
                end
            end
            if (reg_addr == ADDR_W'(FN_BASE + f * FN_STRIDE + OFS_FLD)) begin
                reg_rdata[FIELD_W-1:0] = fn_fld[f];
            end
            for (int k = 0; k < HDR_WORDS; k++) begin
                if (reg_addr == ADDR_W'(FN_BASE + f * FN_STRIDE + OFS_HDR + k)) begin
                    reg_rdata = fn_hdr[f][k];
                end
            end
        end
    end

endmodule

module ierr_router_chk
    import ierr_pkg::*;
#(
    parameter int                 NUM_SRC     = 20,
    parameter logic [NUM_SRC-1:0] DMA_ONLY    = '0,
    parameter logic [NUM_SRC-1:0] BRIDGE_ONLY = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] err_pulse,
    input logic               port_en_q,
    input logic [NUM_SRC-1:0] src_sts,
    input logic [NFUNC-1:0]   fn_corr_sts,
    input logic [NFUNC-1:0]   fn_uncorr_sts,
    input logic [NFUNC-1:0]   fn_hdr_held
);

    localparam logic [NUM_SRC-1:0] SHARED = ~(DMA_ONLY | BRIDGE_ONLY);

    p_log_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_pulse) |=> ((src_sts & $past(err_pulse)) == $past(err_pulse)));

    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en_q |=> (((fn_corr_sts & ~$past(fn_corr_sts)) == '0) &&
                        ((fn_uncorr_sts & ~$past(fn_uncorr_sts)) == '0)));

    p_bridge_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fn_corr_sts[FN_BRIDGE]) || $rose(fn_uncorr_sts[FN_BRIDGE]))
        |-> |($past(err_pulse) & ~DMA_ONLY));

    p_dma_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fn_corr_sts[FN_DMA]) || $rose(fn_uncorr_sts[FN_DMA]))
        |-> |($past(err_pulse) & ~BRIDGE_ONLY));

    p_nt_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fn_corr_sts[FN_NT]) || $rose(fn_uncorr_sts[FN_NT]))
        |-> |($past(err_pulse) & SHARED));

    p_hdr_needs_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_hdr_held & ~fn_uncorr_sts) == '0);

endmodule

bind ierr_router ierr_router_chk #(
    .NUM_SRC     (NUM_SRC),
    .DMA_ONLY    (DMA_ONLY),
    .BRIDGE_ONLY (BRIDGE_ONLY)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .err_pulse     (err_pulse),
    .port_en_q     (port_en_q),
    .src_sts       (src_sts),
    .fn_corr_sts   (fn_corr_sts),
    .fn_uncorr_sts (fn_uncorr_sts),
    .fn_hdr_held   (fn_hdr_held)
);

// File: tb/ierr_router_test.sv
module ierr_router_test;

    localparam int NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  port_mode = 2'd3;
    logic [NS-1:0] err_pulse = '0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  fn_corr_sts, fn_uncorr_sts, fn_hdr_held;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    ierr_router uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .port_mode     (port_mode),
        .err_pulse     (err_pulse),
        .reg_addr      (reg_addr),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .fn_corr_sts   (fn_corr_sts),
        .fn_uncorr_sts (fn_uncorr_sts),
        .fn_hdr_held   (fn_hdr_held)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input int src);
        @(negedge clk);
        err_pulse = '0; err_pulse[src] = 1'b1;
        @(negedge clk);
        err_pulse = '0;
        #1;
    endtask

    task automatic clear_all();
        wr(5'd1, 16'hFFFF);
        wr(5'd2, 16'hFFFF);
        for (int f = 0; f < 3; f++) begin
            wr(5'(8 + 8 * f + 2), 16'h0009);
            wr(5'(8 + 8 * f), 16'h0000);
            wr(5'(8 + 8 * f + 1), 16'h0000);
        end
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(5'd0, d);  check("R10", "enable after reset", d, 16'h0001);
        rd(5'd1, d);  check("R10", "src word0 after reset", d, 16'h0000);
        rd(5'd10, d); check("R10", "bridge fields after reset", d, 16'h0000);
        rd(5'd12, d); check("R10", "bridge header after reset", d, 16'h0000);
        check("R10", "fn status after reset", {fn_corr_sts, fn_uncorr_sts, fn_hdr_held}, 0);
    endtask

    task automatic t_sticky_r1();
        logic [15:0] d;
        pulse(0);
        rd(5'd1, d); check("R1", "source 0 logged", d, 16'h0001);
        // clear and new detection land on the same edge
        @(negedge clk);
        reg_addr = 5'd1; reg_wdata = 16'h0001; reg_wr = 1'b1; err_pulse = 20'h00001;
        @(negedge clk);
        reg_wr = 1'b0; err_pulse = '0;
        rd(5'd1, d); check("R1", "detection beats clear", d, 16'h0001);
        wr(5'd1, 16'h0001);
        rd(5'd1, d); check("R1", "W1C clears", d, 16'h0000);
        pulse(17);
        rd(5'd2, d); check("R1", "source 17 in word1 bit1", d, 16'h0002);
        clear_all();
    endtask

    task automatic t_shared_r8();
        pulse(1);
        check("R8", "correctable shared src1", fn_corr_sts, 3'b111);
        check("R8", "no uncorrectable for src1", fn_uncorr_sts, 3'b000);
        clear_all();
        pulse(3);
        check("R6", "shared src3 all present", fn_uncorr_sts, 3'b111);
        check("R8", "src3 not correctable", fn_corr_sts, 3'b000);
        clear_all();
    endtask

    task automatic t_dma_r4();
        pulse(8);
        check("R4", "DMA src8 uncorr only DMA", fn_uncorr_sts, 3'b100);
        clear_all();
        pulse(9);
        check("R4", "DMA src9 corr only DMA", fn_corr_sts, 3'b100);
        clear_all();
    endtask

    task automatic t_bridge_r5();
        pulse(13);
        check("R5", "promoted src13 corr only bridge", fn_corr_sts, 3'b001);
        clear_all();
        pulse(12);
        check("R5", "promoted src12 uncorr only bridge", fn_uncorr_sts, 3'b001);
        clear_all();
    endtask

    task automatic t_absent_r6();
        logic [15:0] d;
        port_mode = 2'd1;
        pulse(0);
        check("R6", "mode1 bridge+DMA", fn_uncorr_sts, 3'b101);
        rd(5'd18, d); check("R6", "absent NT reads zero", d, 16'h0000);
        wr(5'd16, 16'h0001);
        rd(5'd16, d); check("R6", "absent NT mask write ignored", d, 16'h0000);
        clear_all();
        port_mode = 2'd2;
        pulse(12);
        check("R6", "mode2 promoted with no bridge", fn_uncorr_sts, 3'b000);
        clear_all();
        port_mode = 2'd3;
    endtask

    task automatic t_mask_r7();
        logic [15:0] d;
        wr(5'd9, 16'h0001);
        rd(5'd9, d); check("R7", "bridge mask word1 readback", d, 16'h0001);
        pulse(16);
        check("R7", "src16 blocked at bridge only", fn_uncorr_sts, 3'b110);
        clear_all();
        wr(5'd24, 16'h0002);
        pulse(1);
        check("R7", "src1 blocked at DMA only", fn_corr_sts, 3'b011);
        clear_all();
    endtask

    task automatic t_disable_r2_r3();
        logic [15:0] d;
        wr(5'd10, 16'h0036);
        rd(5'd10, d); check("R3", "fields writable when enabled", d, 16'h0036);
        wr(5'd0, 16'h0000);
        rd(5'd0, d); check("R2", "enable cleared", d, 16'h0000);
        pulse(3);
        rd(5'd1, d); check("R2", "still logged when disabled", d, 16'h0008);
        check("R2", "no fn status when disabled", {fn_corr_sts, fn_uncorr_sts}, 6'b0);
        wr(5'd10, 16'h0000);
        rd(5'd10, d); check("R3", "fields frozen when disabled", d, 16'h0036);
        wr(5'd0, 16'h0001);
        clear_all();
        rd(5'd10, d); check("R3", "fields writable after re-enable", d, 16'h0000);
    endtask

    task automatic t_header_r9();
        logic [15:0] d;
        pulse(2);
        check("R9", "header held all functions", fn_hdr_held, 3'b111);
        rd(5'd12, d); check("R9", "bridge header word0 ones", d, 16'hFFFF);
        rd(5'd31, d); check("R9", "DMA header word3 ones", d, 16'hFFFF);
        wr(5'd10, 16'h0001);
        rd(5'd12, d); check("R9", "released header zero", d, 16'h0000);
        check("R9", "bridge header released", fn_hdr_held, 3'b110);
        wr(5'd10, 16'h0002);
        pulse(0);
        rd(5'd10, d); check("R9", "masked uncorr status set", d, 16'h0003);
        rd(5'd13, d); check("R9", "masked uncorr no header", d, 16'h0000);
        check("R9", "masked bridge not held", fn_hdr_held[0], 1'b0);
        clear_all();
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sticky_r1();
        t_shared_r8();
        t_dma_r4();
        t_bridge_r5();
        t_absent_r6();
        t_mask_r7();
        t_disable_r2_r3();
        t_header_r9();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule